// File: doc/BRIEF.md
# DS3 Transmit Framer with Overhead Merge

This block assembles outbound DS3 M-frames in C-bit parity format and sends them as one serial bit per clock toward a line interface. A free-running position counter walks through the 4760 bit slots of a frame: 7 subframes, each holding 8 blocks of one overhead bit and 84 payload bits. On each payload slot the block raises a request strobe and passes the payload input straight through. On each overhead slot it picks a source for the bit. Framing, multiframe and parity bits are produced internally and can never be overridden. The user-insertable fields come from a user overhead port when that port is enabled, and from built-in defaults when it is not. The FEAC and data-link fields can also come from an HDLC source.

Inputs are sampled combinationally in the slot in which the matching strobe is high. The serial output and the frame-start marker are registered, so they appear one clock after their slot. The parity of all payload bits in one frame is accumulated as the frame goes out. That parity is then carried in both parity positions of the following frame.

Top module: `ds3_tx_framer`

## Requirements
- R1: A frame is 4760 clock cycles long. `tx_fs` is high for exactly one cycle, together with the first bit of each frame. `tx_bit`/`tx_fs` show slot n in the cycle after slot n. Slot index k maps to subframe k/680, block (k%680)/85 and bit (k%85). Bit 0 of a block is its overhead bit.
- R2: `pay_req` is high exactly on payload slots (bit index not 0). On those slots `tx_bit` carries the `pay_bit` value sampled in that slot.
- R3: The overhead bits of blocks 1, 3, 5 and 7 carry 1, 0, 0, 1 in every subframe, whatever the state of `oh_en` and `oh_bit`.
- R4: The block-0 overhead bit of subframes 5, 6 and 7 carries 0, 1, 0, whatever the state of the overhead port.
- R5: The block-0 overhead bits of subframes 3 and 4 both equal the XOR of all payload bits of the previous frame. They are 0 in the first frame after reset, and the overhead port cannot change them.
- R6: `oh_req` is high only on user-insertable slots, and `oh_field` names the field with this code: 1 = X (block 0 of subframes 1-2), 2 = FEBE (C bits of subframe 4), 3 = FEAC (block 6 of subframe 1), 4 = DL (C bits of subframe 5), 5 = UDL (C bits of subframes 2, 6, 7), 6 = CP (C bits of subframe 3). C bits sit in blocks 2, 4 and 6. On every other slot `oh_field` is 0.
- R7: While `oh_en` is high, the X, FEBE, UDL and CP slots carry `oh_bit` as sampled in that slot.
- R8: While `oh_en` is low, X, FEBE and UDL carry 1 and CP carries the computed parity value. The C bits of blocks 2 and 4 in subframe 1 always carry 1.
- R9: While `hdlc_en` is high, the FEAC and DL slots carry `hdlc_bit` and raise `hdlc_req`. This holds even when `oh_en` is high.
- R10: While `hdlc_en` is low, the FEAC and DL slots carry `oh_bit` if `oh_en` is high and 1 otherwise, and `hdlc_req` stays low.
- R11: During reset `tx_bit` and `tx_fs` are 0 and the position returns to the first slot of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pay_bit | input | 1 | Payload bit for the current slot |
| oh_en | input | 1 | User overhead port active |
| oh_bit | input | 1 | User overhead bit for the current slot |
| hdlc_en | input | 1 | HDLC source enabled |
| hdlc_bit | input | 1 | HDLC bit for the current FEAC/DL slot |
| pay_req | output | 1 | Current slot takes a payload bit |
| oh_req | output | 1 | Current slot is user-insertable |
| oh_field | output | 3 | Field code of the current user-insertable slot |
| hdlc_req | output | 1 | Current slot takes an HDLC bit |
| tx_bit | output | 1 | Registered serial line bit |
| tx_fs | output | 1 | Registered frame-start marker |

## Verification
The assertions assume that `pay_bit`, `oh_bit` and `hdlc_bit` are valid in the same cycle as the strobe that asks for them. They also assume that `oh_en` and `hdlc_en` are steady through the slot they select. The stimulus drives every data input freshly at each falling edge, from an independent model of the slot map. It changes the two enables only at frame boundaries. Over successive frames it covers all four enable combinations, and it includes a frame with an odd payload count and a frame with no payload ones, so both parity values are seen.

// File: rtl/ds3f_pkg.sv
package ds3f_pkg;

    localparam int SF_N       = 7;
    localparam int BLK_N      = 8;
    localparam int PAY_N      = 84;
    localparam int BLK_BITS   = PAY_N + 1;
    localparam int FRAME_BITS = SF_N * BLK_N * BLK_BITS;
    localparam int BIT_W      = $clog2(BLK_BITS);
    localparam int BLK_W      = $clog2(BLK_N);
    localparam int SF_W       = $clog2(SF_N);
    localparam int FLD_W      = 3;

    typedef enum logic [FLD_W-1:0] {
        FLD_NONE = 3'd0,
        FLD_X    = 3'd1,
        FLD_FEBE = 3'd2,
        FLD_FEAC = 3'd3,
        FLD_DL   = 3'd4,
        FLD_UDL  = 3'd5,
        FLD_CP   = 3'd6
    } field_e;

    typedef enum logic [2:0] {
        SK_PAY,
        SK_FRM,
        SK_MFR,
        SK_PAR,
        SK_CONST,
        SK_USER
    } kind_e;

    typedef struct packed {
        logic [SF_W-1:0]  sf;
        logic [BLK_W-1:0] blk;
        logic [BIT_W-1:0] bit_idx;
    } pos_t;

    typedef struct packed {
        kind_e  kind;
        field_e field;
        logic   fixed_val;
    } slot_t;

    // Classify a slot position into its source kind and field.
    function automatic slot_t classify(pos_t p);
        slot_t s;
        s.kind      = SK_CONST;
        s.field     = FLD_NONE;
        s.fixed_val = 1'b1;
        if (p.bit_idx != '0) begin
            s.kind      = SK_PAY;
            s.fixed_val = 1'b0;
        end else if (p.blk[0]) begin
            s.kind      = SK_FRM;
            s.fixed_val = (p.blk == BLK_W'(1)) || (p.blk == BLK_W'(BLK_N - 1));
        end else if (p.blk == '0) begin
            if (p.sf < SF_W'(2)) begin
                s.kind  = SK_USER;
                s.field = FLD_X;
            end else if (p.sf < SF_W'(4)) begin
                s.kind  = SK_PAR;
            end else begin
                s.kind      = SK_MFR;
                s.fixed_val = (p.sf == SF_W'(5));
            end
        end else begin
            s.kind = SK_USER;
            case (p.sf)
                SF_W'(0): begin
                    if (p.blk == BLK_W'(6)) s.field = FLD_FEAC;
                    else                    s.kind  = SK_CONST;
                end
                SF_W'(2): s.field = FLD_CP;
                SF_W'(3): s.field = FLD_FEBE;
                SF_W'(4): s.field = FLD_DL;
                default:  s.field = FLD_UDL;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/ds3f_pos_counter.sv
module ds3f_pos_counter
    import ds3f_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output pos_t pos,
    output logic frame_last
);
    localparam logic [BIT_W-1:0] BIT_MAX = BIT_W'(BLK_BITS - 1);
    localparam logic [BLK_W-1:0] BLK_MAX = BLK_W'(BLK_N - 1);
    localparam logic [SF_W-1:0]  SF_MAX  = SF_W'(SF_N - 1);

    logic bit_wrap;
    logic blk_wrap;

    assign bit_wrap   = (pos.bit_idx == BIT_MAX);
    assign blk_wrap   = bit_wrap && (pos.blk == BLK_MAX);
    assign frame_last = blk_wrap && (pos.sf == SF_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else begin
            pos.bit_idx <= bit_wrap ? '0 : pos.bit_idx + 1'b1;
            if (bit_wrap) begin
                pos.blk <= blk_wrap ? '0 : pos.blk + 1'b1;
            end
            if (blk_wrap) begin
                pos.sf <= frame_last ? '0 : pos.sf + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ds3f_parity.sv
module ds3f_parity (
    input  logic clk,
    input  logic rst,
    input  logic pay_req,
    input  logic pay_bit,
    input  logic frame_last,
    output logic p_val
);
    logic acc;
    logic acc_next;

    assign acc_next = acc ^ (pay_req & pay_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= 1'b0;
            p_val <= 1'b0;
        end else if (frame_last) begin
            p_val <= acc_next;
            acc   <= 1'b0;
        end else begin
            acc   <= acc_next;
        end
    end
endmodule

// File: rtl/ds3f_oh_mux.sv
module ds3f_oh_mux
    import ds3f_pkg::*;
(
    input  slot_t             slot,
    input  logic              p_val,
    input  logic              oh_en,
    input  logic              oh_bit,
    input  logic              hdlc_en,
    input  logic              hdlc_bit,
    output logic              oh_val,
    output logic              oh_req,
    output logic [FLD_W-1:0]  oh_field,
    output logic              hdlc_req
);
    logic link_slot;

    assign link_slot = (slot.kind == SK_USER) &&
                       ((slot.field == FLD_FEAC) || (slot.field == FLD_DL));

    always_comb begin
        oh_val = 1'b0;
        case (slot.kind)
            SK_FRM, SK_MFR, SK_CONST: oh_val = slot.fixed_val;
            SK_PAR:                   oh_val = p_val;
            SK_USER: begin
                if (link_slot)
                    oh_val = hdlc_en ? hdlc_bit : (oh_en ? oh_bit : 1'b1);
                else if (slot.field == FLD_CP)
                    oh_val = oh_en ? oh_bit : p_val;
                else
                    oh_val = oh_en ? oh_bit : 1'b1;
            end
            default:                  oh_val = 1'b0;
        endcase
    end

    assign oh_req   = (slot.kind == SK_USER);
    assign oh_field = oh_req ? slot.field : FLD_NONE;
    assign hdlc_req = link_slot && hdlc_en;
endmodule

// File: rtl/ds3_tx_framer.sv
module ds3_tx_framer
    import ds3f_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pay_bit,
    input  logic             oh_en,
    input  logic             oh_bit,
    input  logic             hdlc_en,
    input  logic             hdlc_bit,
    output logic             pay_req,
    output logic             oh_req,
    output logic [FLD_W-1:0] oh_field,
    output logic             hdlc_req,
    output logic             tx_bit,
    output logic             tx_fs
);
    pos_t  pos;
    slot_t slot;
    logic  frame_last;
    logic  p_val;
    logic  oh_val;
    logic  frame_first;

    ds3f_pos_counter u_pos (
        .clk        (clk),
        .rst        (rst),
        .pos        (pos),
        .frame_last (frame_last)
    );

    assign slot        = classify(pos);
    assign pay_req     = (slot.kind == SK_PAY);
    assign frame_first = (pos == '0);

    ds3f_parity u_par (
        .clk        (clk),
        .rst        (rst),
        .pay_req    (pay_req),
        .pay_bit    (pay_bit),
        .frame_last (frame_last),
        .p_val      (p_val)
    );

    ds3f_oh_mux u_mux (
        .slot     (slot),
        .p_val    (p_val),
        .oh_en    (oh_en),
        .oh_bit   (oh_bit),
        .hdlc_en  (hdlc_en),
        .hdlc_bit (hdlc_bit),
        .oh_val   (oh_val),
        .oh_req   (oh_req),
        .oh_field (oh_field),
        .hdlc_req (hdlc_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_bit <= 1'b0;
            tx_fs  <= 1'b0;
        end else begin
            tx_bit <= pay_req ? pay_bit : oh_val;
            tx_fs  <= frame_first;
        end
    end
endmodule

// File: rtl/ds3_tx_framer_checker.sv
module ds3_tx_framer_checker
    import ds3f_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input pos_t             pos,
    input logic             pay_req,
    input logic             pay_bit,
    input logic             oh_req,
    input logic [FLD_W-1:0] oh_field,
    input logic             oh_en,
    input logic             hdlc_en,
    input logic             tx_bit,
    input logic             tx_fs
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    logic [CNT_W-1:0] since_fs;
    logic             fs_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_fs <= '0;
            fs_seen  <= 1'b0;
        end else if (tx_fs) begin
            since_fs <= '0;
            fs_seen  <= 1'b1;
        end else begin
            since_fs <= since_fs + 1'b1;
        end
    end

    assert_frame_period_R1: assert property (@(posedge clk) disable iff (rst)
        (tx_fs && fs_seen) |-> (since_fs == CNT_W'(FRAME_BITS - 1)));

    assert_payload_pass_R2: assert property (@(posedge clk) disable iff (rst)
        pay_req |=> (tx_bit == $past(pay_bit)));

    assert_fbit_R3: assert property (@(posedge clk) disable iff (rst)
        (pos.bit_idx == '0 && pos.blk[0]) |=>
        (tx_bit == ($past(pos.blk) == BLK_W'(1) || $past(pos.blk) == BLK_W'(BLK_N - 1))));

    assert_mbit_R4: assert property (@(posedge clk) disable iff (rst)
        (pos.bit_idx == '0 && pos.blk == '0 && pos.sf >= SF_W'(4)) |=>
        (tx_bit == ($past(pos.sf) == SF_W'(5))));

    assert_req_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(pay_req && oh_req));

    assert_field_coded_R6: assert property (@(posedge clk) disable iff (rst)
        oh_req |-> (oh_field != FLD_NONE));

    assert_link_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (oh_req && (oh_field == FLD_FEAC || oh_field == FLD_DL) && !hdlc_en && !oh_en)
        |=> tx_bit);
endmodule

bind ds3_tx_framer ds3_tx_framer_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .pos      (pos),
    .pay_req  (pay_req),
    .pay_bit  (pay_bit),
    .oh_req   (oh_req),
    .oh_field (oh_field),
    .oh_en    (oh_en),
    .hdlc_en  (hdlc_en),
    .tx_bit   (tx_bit),
    .tx_fs    (tx_fs)
);

// File: tb/ds3_tx_framer_test.sv
module ds3_tx_framer_test;
    localparam int CLK_P   = 10;
    localparam int FRM     = 4760;
    localparam int NFRAMES = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pay_bit = 1'b0, oh_en = 1'b0, oh_bit = 1'b0;
    logic       hdlc_en = 1'b0, hdlc_bit = 1'b0;
    logic       pay_req, oh_req, hdlc_req, tx_bit, tx_fs;
    logic [2:0] oh_field;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  bval;
        logic  fs;
        string tag;
    } exp_t;

    exp_t sb[$];

    ds3_tx_framer uut (
        .clk(clk), .rst(rst), .pay_bit(pay_bit), .oh_en(oh_en), .oh_bit(oh_bit),
        .hdlc_en(hdlc_en), .hdlc_bit(hdlc_bit), .pay_req(pay_req), .oh_req(oh_req),
        .oh_field(oh_field), .hdlc_req(hdlc_req), .tx_bit(tx_bit), .tx_fs(tx_fs)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp_v, input string what);
        checks++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp_v, $time);
        end
    endtask

    // Field code for an overhead slot, straight from the slot map in R6.
    function automatic int field_of(int sf, int blk);
        if (blk == 0) return (sf < 2) ? 1 : 0;
        if (blk % 2 == 1) return 0;
        case (sf)
            0: return (blk == 6) ? 3 : 0;
            2: return 6;
            3: return 2;
            4: return 4;
            default: return 5;
        endcase
    endfunction

    int p_model = 0;
    int acc     = 0;

    // Driver: drives one slot's inputs, checks strobes, pushes the expected output.
    task automatic drive_slot(input int k, input int fr);
        int   sf, blk, bi, fld, e;
        logic pb, ob, hb;
        string tg;
        sf  = k / 680;
        blk = (k % 680) / 85;
        bi  = k % 85;
        pb  = $urandom % 2;
        ob  = $urandom % 2;
        hb  = $urandom % 2;
        if (fr == 4) pb = (k == 100);
        if (fr == 5) pb = 1'b0;
        pay_bit = pb; oh_bit = ob; hdlc_bit = hb;
        #1;
        fld = (bi == 0) ? field_of(sf, blk) : 0;
        check("R2", pay_req, bi != 0, "pay_req");
        check("R6", oh_req, fld != 0, "oh_req");
        check("R6", oh_field, fld, "oh_field");
        check((fld == 3 || fld == 4) ? "R9" : "R10", hdlc_req,
              (fld == 3 || fld == 4) && hdlc_en, "hdlc_req");
        if (bi != 0) begin
            e = pb; tg = "R2";
            acc ^= pb;
        end else if (blk % 2 == 1) begin
            e = (blk == 1 || blk == 7); tg = "R3";
        end else if (blk == 0 && sf >= 4) begin
            e = (sf == 5); tg = "R4";
        end else if (blk == 0 && sf >= 2) begin
            e = p_model; tg = "R5";
        end else if (fld == 3 || fld == 4) begin
            if (hdlc_en)    begin e = hb; tg = "R9";  end
            else if (oh_en) begin e = ob; tg = "R10"; end
            else            begin e = 1;  tg = "R10"; end
        end else if (fld == 0) begin
            e = 1; tg = "R8";
        end else if (oh_en) begin
            e = ob; tg = "R7";
        end else begin
            e = (fld == 6) ? p_model : 1; tg = "R8";
        end
        sb.push_back('{bval: e[0], fs: (k == 0), tag: tg});
        if (k == FRM - 1) begin
            p_model = acc;
            acc = 0;
        end
    endtask

    // Monitor: pops expected items just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                check(it.tag, tx_bit, it.bval, "tx_bit");
                check("R1", tx_fs, it.fs, "tx_fs");
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R11", tx_bit, 0, "tx_bit in reset");
        check("R11", tx_fs, 0, "tx_fs in reset");
        check("R11", oh_field, 1, "first slot field in reset");
        rst = 1'b0;
        for (int fr = 0; fr < NFRAMES; fr++) begin
            oh_en   = (fr == 1 || fr == 2 || fr == 4);
            hdlc_en = (fr == 2 || fr == 3 || fr == 5);
            for (int k = 0; k < FRM; k++) begin
                drive_slot(k, fr);
                @(negedge clk);
            end
        end
        repeat (3) @(negedge clk);
        check("R1", sb.size(), 0, "scoreboard drained");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule